// File: doc/BRIEF.md
# Debug Memory-Access Command Sequencer

This block performs one debug memory access on a small 16-bit microcontroller that sits behind a JTAG test port. On a start strobe it latches a request: read or write, byte or word, a 16-bit address and write data. It then emits a fixed chain of abstract commands to a downstream serial shifter. The chain polls the target until it reaches an instruction-fetch state, halts the CPU, performs the access and releases the CPU. When the chain is finished, the block presents the read result and pulses done.

The commands are instruction-register shifts, data-register shifts, data-register reads, and TCLK set and clear operations. They travel over a valid/ready request channel. Each command is completed by a response pulse that carries the captured 16-bit value. Every instruction-register shift returns the target's identification byte, which the block checks. A bounded poll limits the wait for the fetch state. Both the poll timeout and an identification mismatch are reported in a two-bit error field. Neither one stops the sequence.

Top module: `dbg_mem_seq`

## Requirements
- R1: A command is held on cmd_valid_o, with cmd_op_o and cmd_data_o stable, until cmd_ready_i is high at a clock edge. The next command is not issued before rsp_valid_i has completed the previous one. Op codes are 0 = IR shift, 1 = DR shift, 2 = DR read, 3 = TCLK set and 4 = TCLK clear. An IR opcode is sent zero-extended in cmd_data_o[7:0]. The data field is zero for DR read and for both TCLK commands.
- R2: Every operation begins with an IR shift of 0x14. DR reads follow until a response has bit 7 (0x0080) set, and each failed read is followed by TCLK clear and then TCLK set.
- R3: The poll stops after POLL_MAX (50) DR reads. If the last of them also fails, err_o[0] is set and the sequence goes on with the halt steps.
- R4: The halt steps are IR 0x41, DR 0x3FFF, TCLK clear, IR 0x13, DR 0x2409 and TCLK set.
- R5: A read issues TCLK clear, IR 0x13, then DR 0x2409 for a word or DR 0x2419 for a byte. It continues with IR 0x83, DR address, IR 0x85, TCLK set, TCLK clear and a DR read. The response to that DR read becomes rdata_o.
- R6: A byte read returns only the low 8 bits of the captured value, zero-extended.
- R7: A write issues TCLK clear, IR 0x13, then DR 0x2408 for a word or DR 0x2418 for a byte. It continues with IR 0x83, DR address, IR 0x85, DR data and TCLK set. For a byte write the data shifted is the low 8 bits of the write data, zero-extended.
- R8: Release issues TCLK clear, IR 0x13, DR 0x2401, IR 0x84 and TCLK set. After the response to that last command, done_o is high for exactly one cycle.
- R9: Any IR shift whose response low byte differs from ID_EXPECT (0x89) sets err_o[1]. The sequence still completes.
- R10: A start strobe while an operation is in progress is ignored. The request fields are latched at the accepted start.
- R11: After reset, done_o, err_o, cmd_valid_o and rdata_o are all zero.
- R12: Accepting a start clears err_o. A write leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one access |
| wr_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| addr_i | input | 16 | Target address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read result |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | [0] fetch poll timeout, [1] identification mismatch |
| cmd_valid_o | output | 1 | Command request valid |
| cmd_ready_i | input | 1 | Shifter accepts the command |
| cmd_op_o | output | 3 | Command op code |
| cmd_data_o | output | 16 | IR opcode or DR value |
| rsp_valid_i | input | 1 | Command completed |
| rsp_data_i | input | 16 | Captured value for the completed command |

## Verification
Word and byte reads are compared with word and byte writes. These show the four control words, the read tail against the write tail, and the low-byte zero extension on byte reads. The fetch poll is tried three ways: success on the first read, success after a few failing reads, and no success at all. The failing reads return every bit except bit 7, which shows that only the fetch bit matters. The full command stream is compared entry by entry with a stream built from the requirements, under a shifter that stalls ready. Separate runs cover a wrong identification byte, a start strobe in the middle of an operation, and a clean operation after an error.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    OP_SHIFT_IR = 3'd0,
    OP_SHIFT_DR = 3'd1,
    OP_READ_DR  = 3'd2,
    OP_TCLK_SET = 3'd3,
    OP_TCLK_CLR = 3'd4
  } cmd_op_t;

  // instruction register opcodes
  localparam logic [7:0] IR_ADDR16     = 8'h83;
  localparam logic [7:0] IR_ADDR_CAP   = 8'h84;
  localparam logic [7:0] IR_DATA_TO_AD = 8'h85;
  localparam logic [7:0] IR_DATA16     = 8'h41;
  localparam logic [7:0] IR_CTRL16     = 8'h13;
  localparam logic [7:0] IR_CTRL_CAP   = 8'h14;

  // control register pieces
  localparam logic [15:0] CW_BASE  = 16'h2400;
  localparam logic [15:0] CW_RNW   = 16'h0001;
  localparam logic [15:0] CW_HALT  = 16'h0008;
  localparam logic [15:0] CW_BYTE  = 16'h0010;
  localparam logic [15:0] JMP_SELF = 16'h3FFF;
  localparam int          FETCH_BIT = 7;

  // step program
  localparam int STEP_W = 5;
  localparam logic [STEP_W-1:0] ST_POLL_IR  = 5'd0;
  localparam logic [STEP_W-1:0] ST_POLL_RD  = 5'd1;
  localparam logic [STEP_W-1:0] ST_POLL_CLR = 5'd2;
  localparam logic [STEP_W-1:0] ST_POLL_SET = 5'd3;
  localparam logic [STEP_W-1:0] ST_HALT0    = 5'd4;
  localparam logic [STEP_W-1:0] ST_HALT1    = 5'd5;
  localparam logic [STEP_W-1:0] ST_HALT2    = 5'd6;
  localparam logic [STEP_W-1:0] ST_HALT3    = 5'd7;
  localparam logic [STEP_W-1:0] ST_HALT4    = 5'd8;
  localparam logic [STEP_W-1:0] ST_HALT5    = 5'd9;
  localparam logic [STEP_W-1:0] ST_ACC0     = 5'd10;
  localparam logic [STEP_W-1:0] ST_ACC1     = 5'd11;
  localparam logic [STEP_W-1:0] ST_ACC2     = 5'd12;
  localparam logic [STEP_W-1:0] ST_ACC3     = 5'd13;
  localparam logic [STEP_W-1:0] ST_ACC4     = 5'd14;
  localparam logic [STEP_W-1:0] ST_ACC5     = 5'd15;
  localparam logic [STEP_W-1:0] ST_TAIL0    = 5'd16;
  localparam logic [STEP_W-1:0] ST_TAIL1    = 5'd17;
  localparam logic [STEP_W-1:0] ST_RESULT   = 5'd18;
  localparam logic [STEP_W-1:0] ST_REL0     = 5'd19;
  localparam logic [STEP_W-1:0] ST_REL1     = 5'd20;
  localparam logic [STEP_W-1:0] ST_REL2     = 5'd21;
  localparam logic [STEP_W-1:0] ST_REL3     = 5'd22;
  localparam logic [STEP_W-1:0] ST_LAST     = 5'd23;

endpackage

// File: rtl/dbg_seq_program.sv
module dbg_seq_program
  import dbg_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic              wr_i,
  input  logic              byte_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output cmd_op_t           op_o,
  output logic [DW-1:0]     data_o
);

  logic [15:0]   ctrl_word;
  logic [DW-1:0] shift_wdata;

  always_comb begin
    ctrl_word = CW_BASE | CW_HALT | (wr_i ? 16'h0000 : CW_RNW) | (byte_i ? CW_BYTE : 16'h0000);
    shift_wdata = byte_i ? DW'(wdata_i[7:0]) : wdata_i;
  end

  always_comb begin
    op_o   = OP_TCLK_CLR;
    data_o = '0;
    case (step_i)
      ST_POLL_IR:  begin op_o = OP_SHIFT_IR; data_o = DW'(IR_CTRL_CAP); end
      ST_POLL_RD:  op_o = OP_READ_DR;
      ST_POLL_CLR: op_o = OP_TCLK_CLR;
      ST_POLL_SET: op_o = OP_TCLK_SET;
      ST_HALT0:    begin op_o = OP_SHIFT_IR; data_o = DW'(IR_DATA16); end
      ST_HALT1:    begin op_o = OP_SHIFT_DR; data_o = DW'(JMP_SELF); end
      ST_HALT2:    op_o = OP_TCLK_CLR;
      ST_HALT3:    begin op_o = OP_SHIFT_IR; data_o = DW'(IR_CTRL16); end
      ST_HALT4:    begin op_o = OP_SHIFT_DR; data_o = DW'(CW_BASE | CW_HALT | CW_RNW); end
      ST_HALT5:    op_o = OP_TCLK_SET;
      ST_ACC0:     op_o = OP_TCLK_CLR;
      ST_ACC1:     begin op_o = OP_SHIFT_IR; data_o = DW'(IR_CTRL16); end
      ST_ACC2:     begin op_o = OP_SHIFT_DR; data_o = DW'(ctrl_word); end
      ST_ACC3:     begin op_o = OP_SHIFT_IR; data_o = DW'(IR_ADDR16); end
      ST_ACC4:     begin op_o = OP_SHIFT_DR; data_o = DW'(addr_i); end
      ST_ACC5:     begin op_o = OP_SHIFT_IR; data_o = DW'(IR_DATA_TO_AD); end
      ST_TAIL0:    if (wr_i) begin op_o = OP_SHIFT_DR; data_o = shift_wdata; end
                   else op_o = OP_TCLK_SET;
      ST_TAIL1:    op_o = wr_i ? OP_TCLK_SET : OP_TCLK_CLR;
      ST_RESULT:   op_o = OP_READ_DR;
      ST_REL0:     op_o = OP_TCLK_CLR;
      ST_REL1:     begin op_o = OP_SHIFT_IR; data_o = DW'(IR_CTRL16); end
      ST_REL2:     begin op_o = OP_SHIFT_DR; data_o = DW'(CW_BASE | CW_RNW); end
      ST_REL3:     begin op_o = OP_SHIFT_IR; data_o = DW'(IR_ADDR_CAP); end
      ST_LAST:     op_o = OP_TCLK_SET;
      default:     op_o = OP_TCLK_CLR;
    endcase
  end

endmodule

// File: rtl/dbg_cmd_port.sv
module dbg_cmd_port
  import dbg_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  cmd_op_t       op_i,
  input  logic [DW-1:0] data_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output cmd_op_t       cmd_op_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= OP_SHIFT_IR;
      cmd_data_o  <= '0;
      waiting     <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !cmd_valid_o && !waiting) begin
        cmd_valid_o <= 1'b1;
        cmd_op_o    <= op_i;
        cmd_data_o  <= data_i;
      end else if (cmd_valid_o && cmd_ready_i) begin
        cmd_valid_o <= 1'b0;
        waiting     <= 1'b1;
      end
      if (waiting && rsp_valid_i) begin
        waiting <= 1'b0;
        done_o  <= 1'b1;
        rdata_o <= rsp_data_i;
      end
    end
  end

  // R1: an offered command holds until accepted
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o));

  // R1: the sequencer only asks for a command when none is outstanding
  p_go_when_free_r1: assert property (@(posedge clk) disable iff (rst)
    go_i |-> !cmd_valid_o && !waiting);

endmodule

// File: rtl/dbg_mem_seq.sv
module dbg_mem_seq
  import dbg_seq_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          POLL_MAX  = 50,
  parameter logic [7:0]  ID_EXPECT = 8'h89
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic          byte_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic [1:0]    err_o,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [2:0]    cmd_op_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i
);

  localparam int PCW = $clog2(POLL_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_t;

  seq_state_t        state;
  logic [STEP_W-1:0] pc;
  logic              wr_q, byte_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic [PCW-1:0]    poll_cnt;

  cmd_op_t           step_op;
  logic [DW-1:0]     step_data;
  cmd_op_t           port_op;
  logic              port_done;
  logic [DW-1:0]     port_rdata;

  dbg_seq_program #(.AW(AW), .DW(DW)) u_prog (
    .step_i (pc),
    .wr_i   (wr_q),
    .byte_i (byte_q),
    .addr_i (addr_q),
    .wdata_i(wdata_q),
    .op_o   (step_op),
    .data_o (step_data)
  );

  dbg_cmd_port #(.DW(DW)) u_port (
    .clk        (clk),
    .rst        (rst),
    .go_i       (state == S_ISSUE),
    .op_i       (step_op),
    .data_i     (step_data),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_op_o   (port_op),
    .cmd_data_o (cmd_data_o),
    .rsp_valid_i(rsp_valid_i),
    .rsp_data_i (rsp_data_i),
    .done_o     (port_done),
    .rdata_o    (port_rdata)
  );

  assign cmd_op_o = port_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pc       <= ST_POLL_IR;
      wr_q     <= 1'b0;
      byte_q   <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      poll_cnt <= '0;
      err_o    <= 2'b00;
      rdata_o  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          wr_q     <= wr_i;
          byte_q   <= byte_i;
          addr_q   <= addr_i;
          wdata_q  <= wdata_i;
          pc       <= ST_POLL_IR;
          poll_cnt <= '0;
          err_o    <= 2'b00;
          state    <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (port_done) begin
          if (step_op == OP_SHIFT_IR && port_rdata[7:0] != ID_EXPECT) err_o[1] <= 1'b1;
          state <= S_ISSUE;
          case (pc)
            ST_POLL_RD: begin
              if (port_rdata[FETCH_BIT]) pc <= ST_HALT0;
              else if (poll_cnt == PCW'(POLL_MAX - 1)) begin
                err_o[0] <= 1'b1;
                pc       <= ST_HALT0;
              end else begin
                poll_cnt <= poll_cnt + PCW'(1);
                pc       <= ST_POLL_CLR;
              end
            end
            ST_POLL_SET: pc <= ST_POLL_RD;
            ST_TAIL1:    pc <= wr_q ? ST_REL0 : ST_RESULT;
            ST_RESULT: begin
              rdata_o <= byte_q ? DW'(port_rdata[7:0]) : port_rdata;
              pc      <= ST_REL0;
            end
            ST_LAST: begin
              done_o <= 1'b1;
              state  <= S_IDLE;
            end
            default: pc <= pc + STEP_W'(1);
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3: the poll count never reaches its limit
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < PCW'(POLL_MAX));

  // R10: no command is offered while the sequencer is idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !cmd_valid_o);

  // R10: a start during an operation leaves the latched request alone
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) && start_i |=> $stable(addr_q) && $stable(wr_q));

  // R12: an accepted start clears the error field
  p_err_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) && start_i |=> err_o == 2'b00);

endmodule

// File: tb/sim_dbg_mem_seq.sv
module sim_dbg_mem_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, wr, byte_sel;
  logic [15:0] addr, wdata;
  logic [15:0] rdata;
  logic        done;
  logic [1:0]  err;
  logic        cmd_valid, cmd_ready;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_data;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  always #4 clk = ~clk;

  dbg_mem_seq u0 (
    .clk(clk), .rst(rst), .start_i(start), .wr_i(wr), .byte_i(byte_sel),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .err_o(err),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_data_o(cmd_data), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data)
  );

  int total = 0, bad = 0;

  // shifter model state
  int          fetch_after = 0;
  logic [7:0]  id_val = 8'h89;
  logic [15:0] mem_val = 16'h0000;
  int          poll_reads = 0;
  logic [7:0]  last_ir = 8'h00;
  int          pend = 0;
  logic [15:0] pend_dat = 16'h0000;
  int          tick = 0;
  int          overlap_err = 0;
  int          log_n = 0;
  logic [2:0]  log_op [0:255];
  logic [15:0] log_dat [0:255];
  int          exp_n = 0;
  logic [2:0]  exp_op [0:255];
  logic [15:0] exp_dat [0:255];

  initial begin
    cmd_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_data  = 16'h0000;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend = pend - 1;
        if (pend == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = pend_dat;
        end
      end
      tick = tick + 1;
      cmd_ready = (tick % 3) != 0;
      if (cmd_valid && (pend > 0 || rsp_valid)) overlap_err = overlap_err + 1;
      if (cmd_valid && cmd_ready && pend == 0 && !rsp_valid) begin
        if (log_n < 256) begin
          log_op[log_n]  = cmd_op;
          log_dat[log_n] = cmd_data;
          log_n = log_n + 1;
        end
        pend_dat = 16'h0000;
        if (cmd_op == 3'd0) begin
          last_ir  = cmd_data[7:0];
          pend_dat = {8'h00, id_val};
        end else if (cmd_op == 3'd2) begin
          if (last_ir == 8'h14) begin
            pend_dat = (poll_reads >= fetch_after) ? 16'h0080 : 16'hFF7F;
            poll_reads = poll_reads + 1;
          end else if (last_ir == 8'h85) pend_dat = mem_val;
        end
        pend = 2;
      end
    end
  end

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] op, input logic [15:0] d);
    exp_op[exp_n]  = op;
    exp_dat[exp_n] = d;
    exp_n = exp_n + 1;
  endtask

  task automatic build_exp(input logic w, input logic b, input logic [15:0] a, input logic [15:0] d, input int fa);
    int nr;
    logic [15:0] ctrl;
    exp_n = 0;
    push(3'd0, 16'h0014);
    nr = (fa + 1 > 50) ? 50 : fa + 1;
    for (int i = 0; i < nr; i++) begin
      push(3'd2, 16'h0);
      if (i < nr - 1) begin push(3'd4, 16'h0); push(3'd3, 16'h0); end
    end
    push(3'd0, 16'h0041); push(3'd1, 16'h3FFF); push(3'd4, 16'h0);
    push(3'd0, 16'h0013); push(3'd1, 16'h2409); push(3'd3, 16'h0);
    ctrl = 16'h2408 | (w ? 16'h0 : 16'h1) | (b ? 16'h0010 : 16'h0);
    push(3'd4, 16'h0); push(3'd0, 16'h0013); push(3'd1, ctrl);
    push(3'd0, 16'h0083); push(3'd1, a); push(3'd0, 16'h0085);
    if (w) begin
      push(3'd1, b ? {8'h00, d[7:0]} : d); push(3'd3, 16'h0);
    end else begin
      push(3'd3, 16'h0); push(3'd4, 16'h0); push(3'd2, 16'h0);
    end
    push(3'd4, 16'h0); push(3'd0, 16'h0013); push(3'd1, 16'h2401);
    push(3'd0, 16'h0084); push(3'd3, 16'h0);
  endtask

  task automatic compare_seq(input string tag);
    int first = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (first < 0 && (log_op[i] != exp_op[i] || log_dat[i] != exp_dat[i])) first = i;
    check(log_n == exp_n, {tag, " R1/R2/R4/R8 command count"}, log_n, exp_n);
    if (first >= 0)
      check(1'b0, $sformatf("%s R2/R4/R5/R7/R8 entry %0d", tag, first),
            {13'h0, log_op[first], log_dat[first]}, {13'h0, exp_op[first], exp_dat[first]});
    else check(1'b1, tag, 0, 0);
    check(overlap_err == 0, {tag, " R1 one outstanding command"}, overlap_err, 0);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, {tag, " R8 done seen"}, done, 1);
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic kick(input logic w, input logic b, input logic [15:0] a, input logic [15:0] d);
    log_n = 0; poll_reads = 0; overlap_err = 0; last_ir = 8'h00;
    @(negedge clk);
    wr = w; byte_sel = b; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    check(done == 1'b0 && cmd_valid == 1'b0, "R11 reset done/valid", {done, cmd_valid}, 0);
    check(err == 2'b00, "R11 reset err", err, 0);
    check(rdata == 16'h0, "R11 reset rdata", rdata, 0);
  endtask

  task automatic t_word_read;
    fetch_after = 0; id_val = 8'h89; mem_val = 16'hBEEF;
    kick(1'b0, 1'b0, 16'h0FF0, 16'h0);
    wait_done("word read");
    build_exp(1'b0, 1'b0, 16'h0FF0, 16'h0, 0);
    compare_seq("word read");
    check(rdata == 16'hBEEF, "R5 word read data", rdata, 16'hBEEF);
    check(err == 2'b00, "R9 word read err", err, 0);
  endtask

  task automatic t_byte_read;
    fetch_after = 3; mem_val = 16'hA55A;
    kick(1'b0, 1'b1, 16'h0200, 16'h0);
    wait_done("byte read");
    build_exp(1'b0, 1'b1, 16'h0200, 16'h0, 3);
    compare_seq("byte read R2 poll");
    check(rdata == 16'h005A, "R6 byte read zero-extend", rdata, 16'h005A);
  endtask

  task automatic t_word_write;
    fetch_after = 1;
    kick(1'b1, 1'b0, 16'h0120, 16'h5A80);
    wait_done("word write");
    build_exp(1'b1, 1'b0, 16'h0120, 16'h5A80, 1);
    compare_seq("word write R7");
    check(rdata == 16'h005A, "R12 write keeps rdata", rdata, 16'h005A);
  endtask

  task automatic t_byte_write;
    fetch_after = 0;
    kick(1'b1, 1'b1, 16'h0301, 16'h1234);
    wait_done("byte write");
    build_exp(1'b1, 1'b1, 16'h0301, 16'h1234, 0);
    compare_seq("byte write R7");
  endtask

  task automatic t_fetch_timeout;
    fetch_after = 1000; mem_val = 16'h0F0F;
    kick(1'b0, 1'b0, 16'h0400, 16'h0);
    wait_done("timeout");
    build_exp(1'b0, 1'b0, 16'h0400, 16'h0, 1000);
    compare_seq("timeout R3");
    check(poll_reads == 50, "R3 poll read count", poll_reads, 50);
    check(err == 2'b01, "R3 timeout flag", err, 1);
    check(rdata == 16'h0F0F, "R3 access still done", rdata, 16'h0F0F);
  endtask

  task automatic t_err_clears;
    fetch_after = 0; mem_val = 16'h1111;
    kick(1'b0, 1'b0, 16'h0500, 16'h0);
    check(err == 2'b00, "R12 err cleared at start", err, 0);
    wait_done("clear");
    check(err == 2'b00, "R12 err stays clear", err, 0);
  endtask

  task automatic t_bad_id;
    fetch_after = 0; id_val = 8'h77; mem_val = 16'h2468;
    kick(1'b0, 1'b0, 16'h0600, 16'h0);
    wait_done("bad id");
    build_exp(1'b0, 1'b0, 16'h0600, 16'h0, 0);
    compare_seq("bad id R9");
    check(err == 2'b10, "R9 id mismatch flag", err, 2);
    check(rdata == 16'h2468, "R9 access completes", rdata, 16'h2468);
    id_val = 8'h89;
  endtask

  task automatic t_busy_start;
    int n_after;
    fetch_after = 2; mem_val = 16'h7777;
    kick(1'b0, 1'b0, 16'h1000, 16'h0);
    repeat (30) @(negedge clk);
    wr = 1'b1; addr = 16'h2222; wdata = 16'hDEAD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("busy");
    build_exp(1'b0, 1'b0, 16'h1000, 16'h0, 2);
    compare_seq("busy R10");
    check(rdata == 16'h7777, "R10 original read kept", rdata, 16'h7777);
    n_after = log_n;
    repeat (300) @(negedge clk);
    check(log_n == n_after && done == 1'b0, "R10 no second operation", log_n, n_after);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; wr = 1'b0; byte_sel = 1'b0;
    addr = 16'h0; wdata = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word_read();
    t_byte_read();
    t_word_write();
    t_byte_write();
    t_fetch_timeout();
    t_err_clears();
    t_bad_id();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule